// File: doc/BRIEF.md
# Parallel Video Transmit Pixel Formatter

This block feeds the transmit side of a parallel video port. It takes 32-bit words from a memory or DMA stream and splits them into output units of 8, 16 or 24 bits. Each unit leaves as one sample on a valid/ready port. A configuration bit chooses the unpacking order: either the least significant byte or half-word goes out first, or the most significant one does. In 24-bit mode the bytes of consecutive words form one continuous stream, so three input words give four pixels.

Two optional stages follow the unpacker. In 24-bit mode, colour reduction turns an RGB888 pixel into RGB666 or RGB565. In 8-bit mode, clipping holds each output byte inside a programmed range. Each stage can be left out of the build with a parameter.

The configuration inputs are static. They may change only while no bytes are held, which is after reset or once a stream has drained. Frame syncs, blanking and clock gating are handled elsewhere.

Top module: `vid_tx_fmt`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: With `cfg_unit`=00 (8-bit), each word gives four samples in `out_data[7:0]`, with `out_data[23:8]`=0. With `cfg_msb_first`=0 the order is bits 7:0, 15:8, 23:16, 31:24. With `cfg_msb_first`=1 the order is reversed.
- R3: With `cfg_unit`=01 (16-bit), each word gives two samples in `out_data[15:0]`, with `out_data[23:16]`=0. With `cfg_msb_first`=0 bits 15:0 go first. With `cfg_msb_first`=1 bits 31:16 go first.
- R4: With `cfg_unit`=10 or 11 (24-bit), three words w0, w1, w2 give four pixels. With `cfg_msb_first`=0, pixel k is bits [24k+23:24k] of {w2,w1,w0}. With `cfg_msb_first`=1, pixel k is bits [95-24k:72-24k] of {w0,w1,w2}.
- R5: `in_ready` is 1 exactly when fewer bytes are held than one unit needs (1, 2 or 3 bytes). A word is taken only on `in_valid` and `in_ready`, so no word is taken while a full unit is still waiting.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_data` holds its value on the next cycle.
- R7: With `cfg_conv`=01 in 24-bit mode, the pixel is split as red = bits 23:16, green = 15:8 and blue = 7:0. The output is {R[7:2],G[7:2],B[7:2]} in `out_data[17:0]`, with the upper bits 0.
- R8: With `cfg_conv`=10 in 24-bit mode, the output is {R[7:3],G[7:2],B[7:3]} in `out_data[15:0]`, with the upper bits 0.
- R9: `cfg_conv` of 00 or 11 passes the 24-bit pixel unchanged. In 8-bit and 16-bit modes, `cfg_conv` has no effect.
- R10: In 8-bit mode with `cfg_clip_en`=1, a value below `clip_lo` is output as `clip_lo`. Otherwise, a value above `clip_hi` is output as `clip_hi`, and any other value is unchanged. With `cfg_clip_en`=0, or in 16-bit and 24-bit modes, no clipping is applied.
- R11: `out_valid` is 1 exactly when a full unit is held. Under any pattern of `in_valid` and `out_ready`, every input byte leaves exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_unit | input | 2 | Unit size: 00 = 8-bit, 01 = 16-bit, 1x = 24-bit |
| cfg_msb_first | input | 1 | 1 = unpack from the most significant end |
| cfg_conv | input | 2 | Colour reduction: 01 = RGB666, 10 = RGB565, others = none |
| cfg_clip_en | input | 1 | Enables clipping in 8-bit mode |
| clip_lo | input | 8 | Lower clip limit |
| clip_hi | input | 8 | Upper clip limit |
| in_valid | input | 1 | Input word valid |
| in_word | input | 32 | Packed input word |
| in_ready | output | 1 | Formatter can take a word |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Port takes the sample |
| out_data | output | 24 | Output sample, right-justified |

## Verification
The hardest state to reach is a 24-bit stream whose leftover bytes straddle words. The buffer then holds one or two bytes of a pixel while the next word arrives, and a backpressure stall lands on exactly that pixel. The bench gets there by sending long runs of 24-bit words, always in multiples of three, with random `in_valid` and `out_ready`, in both orders and with each reduction. A behavioural byte-queue model predicts `in_ready`, `out_valid` and `out_data` on every cycle, so misalignment at any straddle point shows up. Fixed word patterns with known expected values cover each order and unit size on their own.

// File: rtl/vtf_pkg.sv
package vtf_pkg;

   typedef enum logic [1:0] {
      UNIT_B8   = 2'b00,
      UNIT_B16  = 2'b01,
      UNIT_B24  = 2'b10,
      UNIT_B24X = 2'b11
   } unit_e;

   typedef enum logic [1:0] {
      CONV_NONE  = 2'b00,
      CONV_666   = 2'b01,
      CONV_565   = 2'b10,
      CONV_NONEX = 2'b11
   } conv_e;

   // number of bytes one output unit consumes
   function automatic logic [1:0] unit_bytes(input logic [1:0] u);
      case (u)
         UNIT_B8:  return 2'd1;
         UNIT_B16: return 2'd2;
         default:  return 2'd3;
      endcase
   endfunction

endpackage

// File: rtl/fmt_unpack.sv
module fmt_unpack #(
   parameter int WORD_BYTES = 4,
   parameter int BUF_BYTES  = 8,
   parameter int UNIT_MAX   = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [1:0]                unit,
   input  logic                      msb_first,
   input  logic                      in_valid,
   input  logic [8*WORD_BYTES-1:0]   in_word,
   output logic                      in_ready,
   output logic                      out_valid,
   input  logic                      out_ready,
   output logic [8*UNIT_MAX-1:0]     out_raw
);
   import vtf_pkg::*;

   localparam int CNT_W = $clog2(BUF_BYTES + 1);
   localparam int RAW_W = 8 * UNIT_MAX;

   if (BUF_BYTES < WORD_BYTES + UNIT_MAX - 1) begin : g_bad_depth
      $error("fmt_unpack: BUF_BYTES too small for one word plus a partial unit");
   end
   if (WORD_BYTES < UNIT_MAX) begin : g_bad_word
      $error("fmt_unpack: WORD_BYTES must cover the largest unit");
   end

   logic [7:0]       byte_q [BUF_BYTES];
   logic [CNT_W-1:0] fill;
   logic [1:0]       need;
   logic             take_in;
   logic             take_out;

   assign need      = unit_bytes(unit);
   assign in_ready  = fill < CNT_W'(need);
   assign out_valid = fill >= CNT_W'(need);
   assign take_in   = in_valid && in_ready;
   assign take_out  = out_valid && out_ready;

   function automatic logic [7:0] pick_byte(input logic [8*WORD_BYTES-1:0] w,
                                            input logic msb, input int j);
      if (msb) return w[8*(WORD_BYTES-1-j) +: 8];
      else     return w[8*j +: 8];
   endfunction

   // unit assembly: lanes below the unit size contribute
   always_comb begin
      out_raw = '0;
      for (int i = 0; i < UNIT_MAX; i++) begin
         if (i < int'(need)) begin
            if (msb_first) out_raw = {out_raw[RAW_W-9:0], byte_q[i]};
            else           out_raw[8*i +: 8] = byte_q[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill <= '0;
         for (int k = 0; k < BUF_BYTES; k++) byte_q[k] <= '0;
      end else if (take_in) begin
         for (int k = 0; k < BUF_BYTES; k++) begin
            if (k >= int'(fill) && k < int'(fill) + WORD_BYTES)
               byte_q[k] <= pick_byte(in_word, msb_first, k - int'(fill));
         end
         fill <= fill + CNT_W'(WORD_BYTES);
      end else if (take_out) begin
         for (int k = 0; k < BUF_BYTES; k++) begin
            if (k + int'(need) < BUF_BYTES) byte_q[k] <= byte_q[k + int'(need)];
            else                             byte_q[k] <= '0;
         end
         fill <= fill - CNT_W'(need);
      end
   end

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CNT_W'(BUF_BYTES));

   // R5
   word_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> fill == $past(fill) + CNT_W'(WORD_BYTES));

   // R11
   unit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |=> fill == $past(fill) - CNT_W'($past(need)));

endmodule

// File: rtl/fmt_rgb_reduce.sv
module fmt_rgb_reduce #(
   parameter bit HAS_CONV = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        is24,
   input  logic [1:0]  conv,
   input  logic [23:0] pix_in,
   output logic [23:0] pix_out
);
   import vtf_pkg::*;

   if (HAS_CONV) begin : g_conv
      logic [7:0] r, g, b;
      assign r = pix_in[23:16];
      assign g = pix_in[15:8];
      assign b = pix_in[7:0];
      always_comb begin
         pix_out = pix_in;
         if (is24) begin
            case (conv)
               CONV_666: pix_out = {6'd0, r[7:2], g[7:2], b[7:2]};
               CONV_565: pix_out = {8'd0, r[7:3], g[7:2], b[7:3]};
               default:  pix_out = pix_in;
            endcase
         end
      end
   end else begin : g_pass
      assign pix_out = pix_in;
   end

   // R7
   rgb666_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_CONV && is24 && conv == CONV_666) |-> pix_out < 24'h040000);

   // R8
   rgb565_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_CONV && is24 && conv == CONV_565) |-> pix_out < 24'h010000);

endmodule

// File: rtl/fmt_clip8.sv
module fmt_clip8 #(
   parameter bit HAS_CLIP = 1'b1,
   parameter int DW       = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [DW-1:0] lo,
   input  logic [DW-1:0] hi,
   input  logic [DW-1:0] val_in,
   output logic [DW-1:0] val_out
);
   if (DW < 1) begin : g_bad_dw
      $error("fmt_clip8: DW must be positive");
   end

   if (HAS_CLIP) begin : g_clip
      always_comb begin
         if (en && val_in < lo)      val_out = lo;
         else if (en && val_in > hi) val_out = hi;
         else                        val_out = val_in;
      end
   end else begin : g_pass
      assign val_out = val_in;
   end

   // R10
   clip_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_CLIP && en && lo <= hi) |-> (val_out >= lo && val_out <= hi));

endmodule

// File: rtl/vid_tx_fmt.sv
module vid_tx_fmt #(
   parameter int WORD_BYTES = 4,
   parameter int BUF_BYTES  = 8,
   parameter bit HAS_CONV   = 1'b1,
   parameter bit HAS_CLIP   = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              cfg_unit,
   input  logic                    cfg_msb_first,
   input  logic [1:0]              cfg_conv,
   input  logic                    cfg_clip_en,
   input  logic [7:0]              clip_lo,
   input  logic [7:0]              clip_hi,
   input  logic                    in_valid,
   input  logic [8*WORD_BYTES-1:0] in_word,
   output logic                    in_ready,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic [23:0]             out_data
);
   import vtf_pkg::*;

   localparam int UNIT_MAX = 3;
   localparam int OUT_W    = 8 * UNIT_MAX;

   if (WORD_BYTES != 4) begin : g_bad_word
      $error("vid_tx_fmt: the port carries 32-bit words");
   end

   logic [OUT_W-1:0] raw;
   logic [OUT_W-1:0] reduced;
   logic [7:0]       clipped;
   logic             is8;

   assign is8 = (cfg_unit == UNIT_B8);

   fmt_unpack #(
      .WORD_BYTES(WORD_BYTES),
      .BUF_BYTES (BUF_BYTES),
      .UNIT_MAX  (UNIT_MAX)
   ) u_unpack (
      .clk      (clk),
      .rst_n    (rst_n),
      .unit     (cfg_unit),
      .msb_first(cfg_msb_first),
      .in_valid (in_valid),
      .in_word  (in_word),
      .in_ready (in_ready),
      .out_valid(out_valid),
      .out_ready(out_ready),
      .out_raw  (raw)
   );

   fmt_rgb_reduce #(.HAS_CONV(HAS_CONV)) u_reduce (
      .clk    (clk),
      .rst_n  (rst_n),
      .is24   (cfg_unit[1]),
      .conv   (cfg_conv),
      .pix_in (raw),
      .pix_out(reduced)
   );

   fmt_clip8 #(.HAS_CLIP(HAS_CLIP), .DW(8)) u_clip (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (cfg_clip_en),
      .lo     (clip_lo),
      .hi     (clip_hi),
      .val_in (raw[7:0]),
      .val_out(clipped)
   );

   assign out_data = is8 ? {16'd0, clipped} : reduced;

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R2
   narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && is8) |-> out_data[23:8] == 16'd0);

endmodule

// File: tb/test_vid_tx_fmt.sv
module test_vid_tx_fmt;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_unit = 2'b00;
   logic        cfg_msb_first = 1'b0;
   logic [1:0]  cfg_conv = 2'b00;
   logic        cfg_clip_en = 1'b0;
   logic [7:0]  clip_lo = 8'h00;
   logic [7:0]  clip_hi = 8'hFF;
   logic        in_valid = 1'b0;
   logic [31:0] in_word = '0;
   logic        in_ready;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [23:0] out_data;

   always #5 clk = ~clk;

   vid_tx_fmt i_vid_tx_fmt (
      .clk(clk), .rst_n(rst_n), .cfg_unit(cfg_unit), .cfg_msb_first(cfg_msb_first),
      .cfg_conv(cfg_conv), .cfg_clip_en(cfg_clip_en), .clip_lo(clip_lo), .clip_hi(clip_hi),
      .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   int n_vec = 0;
   int n_bad = 0;
   logic [7:0]  mq[$];
   logic [31:0] tx_q[$];
   logic [23:0] lit_q[$];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int ubytes();
      return (cfg_unit == 2'b00) ? 1 : (cfg_unit == 2'b01) ? 2 : 3;
   endfunction

   function automatic logic [23:0] model_unit();
      logic [23:0] v = '0;
      logic [7:0]  b;
      int n = ubytes();
      for (int i = 0; i < n; i++) begin
         if (cfg_msb_first) v = (v << 8) | 24'(mq[i]);
         else               v = v | (24'(mq[i]) << (8 * i));
      end
      if (n == 1 && cfg_clip_en) begin
         b = v[7:0];
         if (b < clip_lo)      b = clip_lo;
         else if (b > clip_hi) b = clip_hi;
         v = 24'(b);
      end
      if (n == 3 && cfg_conv == 2'b01) v = {6'd0, v[23:18], v[15:10], v[7:2]};
      if (n == 3 && cfg_conv == 2'b10) v = {8'd0, v[23:19], v[15:10], v[7:3]};
      return v;
   endfunction

   function automatic string data_tag();
      int n = ubytes();
      if (n == 1) return cfg_clip_en ? "R10" : (cfg_conv != 0 ? "R9" : "R2");
      if (n == 2) return cfg_clip_en ? "R10" : (cfg_conv != 0 ? "R9" : "R3");
      if (cfg_conv == 2'b01) return "R7";
      if (cfg_conv == 2'b10) return "R8";
      return (cfg_conv == 2'b11) ? "R9" : "R4";
   endfunction

   // one segment: drive tx_q with random valid/ready, compare every cycle
   task automatic run_seg(input int vp, input int rp);
      bit          m_ready, m_valid, prev_stall;
      logic [23:0] prev_data, m_data;
      int          guard;
      prev_stall = 0;
      prev_data  = '0;
      guard      = 0;
      while ((tx_q.size() > 0 || mq.size() >= ubytes()) && guard < 4000) begin
         guard++;
         @(negedge clk);
         m_ready = mq.size() < ubytes();
         m_valid = !m_ready;
         m_data  = m_valid ? model_unit() : '0;
         chk(in_ready == m_ready, "R5 in_ready", 32'(in_ready), 32'(m_ready));
         chk(out_valid == m_valid, "R11 out_valid", 32'(out_valid), 32'(m_valid));
         if (m_valid) chk(out_data == m_data, data_tag(), 32'(out_data), 32'(m_data));
         if (prev_stall) chk(out_data == prev_data, "R6 stall hold", 32'(out_data), 32'(prev_data));
         in_valid  = (tx_q.size() > 0) && (($urandom % 100) < vp);
         in_word   = (tx_q.size() > 0) ? tx_q[0] : 32'h0;
         out_ready = (($urandom % 100) < rp);
         prev_stall = m_valid && !out_ready;
         prev_data  = out_data;
         if (m_valid && out_ready && lit_q.size() > 0) begin
            chk(out_data == lit_q[0], {data_tag(), " known"}, 32'(out_data), 32'(lit_q[0]));
            void'(lit_q.pop_front());
         end
         if (in_valid && m_ready) begin
            for (int j = 0; j < 4; j++)
               mq.push_back(cfg_msb_first ? in_word[8*(3-j) +: 8] : in_word[8*j +: 8]);
            void'(tx_q.pop_front());
         end else if (m_valid && out_ready) begin
            for (int j = 0; j < ubytes(); j++) void'(mq.pop_front());
         end
      end
      @(negedge clk);
      in_valid  = 1'b0;
      out_ready = 1'b0;
      chk(guard < 4000, "R11 drain", 32'(guard), 32'd4000);
      chk(lit_q.size() == 0, "R11 known count", 32'(lit_q.size()), 32'd0);
      lit_q.delete();
   endtask

   task automatic set_cfg(input logic [1:0] u, input bit msb, input logic [1:0] cv,
                          input bit ce, input logic [7:0] lo, input logic [7:0] hi);
      @(negedge clk);
      cfg_unit = u; cfg_msb_first = msb; cfg_conv = cv;
      cfg_clip_en = ce; clip_lo = lo; clip_hi = hi;
   endtask

   task automatic rand_words(input int n);
      for (int i = 0; i < n; i++) tx_q.push_back($urandom);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'd1);
      chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);

      // R2 known orders
      set_cfg(2'b00, 0, 2'b00, 0, 8'h00, 8'hFF);
      tx_q.push_back(32'h44332211);
      lit_q = '{24'h11, 24'h22, 24'h33, 24'h44};
      run_seg(100, 100);
      set_cfg(2'b00, 1, 2'b00, 0, 8'h00, 8'hFF);
      tx_q.push_back(32'h44332211);
      lit_q = '{24'h44, 24'h33, 24'h22, 24'h11};
      run_seg(100, 100);

      // R3 known orders
      set_cfg(2'b01, 0, 2'b00, 0, 8'h00, 8'hFF);
      tx_q.push_back(32'hBEEFCAFE);
      lit_q = '{24'h00CAFE, 24'h00BEEF};
      run_seg(100, 100);
      set_cfg(2'b01, 1, 2'b00, 0, 8'h00, 8'hFF);
      tx_q.push_back(32'hBEEFCAFE);
      lit_q = '{24'h00BEEF, 24'h00CAFE};
      run_seg(100, 100);

      // R4 known three-word groups
      set_cfg(2'b10, 0, 2'b00, 0, 8'h00, 8'hFF);
      tx_q = '{32'h03020100, 32'h07060504, 32'h0B0A0908};
      lit_q = '{24'h020100, 24'h050403, 24'h080706, 24'h0B0A09};
      run_seg(100, 100);
      set_cfg(2'b10, 1, 2'b00, 0, 8'h00, 8'hFF);
      tx_q = '{32'h03020100, 32'h07060504, 32'h0B0A0908};
      lit_q = '{24'h030201, 24'h000706, 24'h05040B, 24'h0A0908};
      run_seg(100, 100);

      // R7 / R8 known pixel plus random
      set_cfg(2'b10, 0, 2'b01, 0, 8'h00, 8'hFF);
      tx_q = '{32'h00FC8340, 32'h0, 32'h0};
      lit_q = '{24'h03F810, 24'h0, 24'h0, 24'h0};
      run_seg(100, 100);
      set_cfg(2'b10, 0, 2'b10, 0, 8'h00, 8'hFF);
      tx_q = '{32'h00FC8340, 32'h0, 32'h0};
      lit_q = '{24'h00FC08, 24'h0, 24'h0, 24'h0};
      run_seg(100, 100);

      // R10 clipping edges
      set_cfg(2'b00, 0, 2'b00, 1, 8'h20, 8'hC0);
      tx_q = '{32'h1F20C0C1, 32'h00FF8021};
      lit_q = '{24'hC0, 24'hC0, 24'h20, 24'h20, 24'h21, 24'h80, 24'hC0, 24'h20};
      run_seg(100, 100);

      // random traffic in every mode with backpressure (R5 R6 R11 R9 R10)
      for (int u = 0; u < 4; u++) begin
         for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 4; c++) begin
               set_cfg(2'(u), m[0], 2'(c), (c == 1), 8'h30, 8'hB0);
               rand_words(u >= 2 ? 24 : 20);
               run_seg(60, 55);
            end
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule